// File: doc/BRIEF.md
# Transmit collision retry controller

This block sits between a byte-wide packet producer and a half-duplex Ethernet transmit path. While a packet streams through, its leading bytes are also written into a local replay store. If the link reports a collision while the current attempt is still inside the collision window, the block restarts the attempt from byte 0 by replaying the stored bytes. The producer is only held off during the replay and never has to send anything twice. It then carries on with the live stream.

The number of restarts is limited by a programmable maximum. When a collision falls outside the window, the packet is aborted as a late collision. When a collision arrives with the retry budget already spent, the packet is aborted as excessive collisions. In both cases the rest of the packet is taken from the producer and thrown away. Each packet yields exactly one status word, whether it completes or aborts. An abort also sets a sticky interrupt flag, and that flag reaches the interrupt line only when it is enabled.

Backoff delay, preamble, frame check sequence and line signalling belong elsewhere. A collision is a single input.

Top module: `tx_retry_ctl`

## Requirements
- R1: With no collision, every producer byte reaches `tx_data` unchanged and in order. `tx_last` is marked on the final byte, and the status word has its flag bits 2:0 all zero.
- R2: A collision while fewer than 64 bytes of the current attempt have been sent restarts the attempt from byte 0 out of the replay store. No byte is lost or reordered, `in_ready` stays low while stored bytes are replayed, and packets of 64 bytes or fewer are fully replayable.
- R3: A collision when 64 or more bytes of the current attempt have been sent aborts at once. The status word then has bit 0 (error) and bit 1 (late collision) set.
- R4: After an abort, `tx_valid` stays low and `in_ready` stays high until the producer's byte marked `in_last` has been taken. None of those bytes are forwarded.
- R5: A collision that arrives when the retries already used equal `cfg_max_retry` aborts the packet. The status word then has bit 0 (error) and bit 2 (excessive collisions) set, and the rest of the packet is discarded as in R4.
- R6: `stat_valid` pulses for one cycle exactly once per packet. It appears in the cycle after the final byte handshake or after the aborting collision. `stat_word` bits 7:4 hold the number of retries actually used, and bit 3 is zero.
- R7: `irq_stat` is set by every abort and stays set until `irq_clr` is high. When a clear and an abort fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when both `irq_stat` and `irq_en` are high.
- R9: A collision before the first byte of a packet has been accepted, or while a packet is being discarded, has no effect on the data, the retry count or the status.
- R10: In a cycle with `col` high, no byte moves on the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer byte valid |
| in_data | input | 8 | Producer byte |
| in_last | input | 1 | Producer byte is the last of the packet |
| in_ready | output | 1 | Block accepts the producer byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends the packet |
| tx_ready | input | 1 | Transmit side takes the byte |
| col | input | 1 | Collision seen on the medium |
| cfg_max_retry | input | 4 | Maximum number of restarts per packet |
| irq_en | input | 1 | Enable for the interrupt line |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| stat_valid | output | 1 | Status word strobe |
| stat_word | output | 8 | Flags in bits 2:0, retries used in bits 7:4 |
| irq_stat | output | 1 | Sticky abort flag |
| irq | output | 1 | Masked interrupt |

## Verification
An abort setting the sticky flag and software clearing that flag can land in the same cycle. The bench provokes this by raising `irq_clr` in exactly the cycle in which it drives the late collision. It then judges the outcome at the status strobe, where `irq_stat` must still read 1. A later clear issued on its own must then bring the flag to 0. A second overlap, a collision arriving in the very cycle that the replay hands back to the live stream, is driven by placing the second collision at the replayed length, and its outcome is judged from the status word and the count of bytes sent.

// File: rtl/tx_retry_ctl.sv
module tx_retry_ctl #(
  parameter int WIN = 64,
  parameter int DW  = 8,
  parameter int RW  = 4,
  localparam int CW = $clog2(WIN + 1),
  localparam int AW = $clog2(WIN),
  localparam int SW = RW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          col,
  input  logic [RW-1:0] cfg_max_retry,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          stat_valid,
  output logic [SW-1:0] stat_word,
  output logic          irq_stat,
  output logic          irq
);

  logic [DW-1:0] mem [WIN];
  logic [CW-1:0] cnt, wr_cnt;
  logic [RW-1:0] rcnt;
  logic          act, drain;

  wire replay    = act && !drain && (cnt < wr_cnt);
  wire col_hit   = col && act && !drain;
  wire late      = col_hit && (cnt == CW'(WIN));
  wire excess    = col_hit && !late && (rcnt == cfg_max_retry);
  wire retry     = col_hit && !late && !excess;
  wire abort     = late || excess;
  wire tx_hs     = tx_valid && tx_ready;
  wire done_ok   = tx_hs && !replay && in_last;
  wire drain_end = drain && in_valid && in_last;
  wire store     = tx_hs && !replay && (wr_cnt != CW'(WIN));

  assign tx_valid = !col && !drain && (replay || in_valid);
  assign tx_data  = replay ? mem[cnt[AW-1:0]] : in_data;
  assign tx_last  = tx_valid && !replay && in_last;
  assign in_ready = drain || (!col && !replay && tx_ready);
  assign irq      = irq_stat && irq_en;

  always_ff @(posedge clk) begin
    if (store) mem[wr_cnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      wr_cnt     <= '0;
      rcnt       <= '0;
      act        <= 1'b0;
      drain      <= 1'b0;
      stat_valid <= 1'b0;
      stat_word  <= '0;
      irq_stat   <= 1'b0;
    end else begin
      stat_valid <= abort || done_ok;
      if (abort || done_ok) stat_word <= {rcnt, 1'b0, excess, late, abort};

      if (abort) irq_stat <= 1'b1;
      else if (irq_clr) irq_stat <= 1'b0;

      if (abort) begin
        drain  <= 1'b1;
        act    <= 1'b0;
        cnt    <= '0;
        wr_cnt <= '0;
        rcnt   <= '0;
      end else if (drain_end) begin
        drain <= 1'b0;
      end else if (retry) begin
        cnt  <= '0;
        rcnt <= rcnt + 1'b1;
      end else if (done_ok) begin
        act    <= 1'b0;
        cnt    <= '0;
        wr_cnt <= '0;
        rcnt   <= '0;
      end else if (tx_hs) begin
        act <= 1'b1;
        if (cnt != CW'(WIN)) cnt <= cnt + 1'b1;
        if (store) wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_retry_ctl_chk.sv
module tx_retry_ctl_chk #(
  parameter int RW = 4,
  parameter int SW = RW + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          stat_valid,
  input logic [SW-1:0] stat_word,
  input logic          irq_stat,
  input logic          irq,
  input logic          irq_en,
  input logic          irq_clr,
  input logic [RW-1:0] cfg_max_retry
);

  p_abort_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_word[0] |-> irq_stat);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat && !irq_clr |=> irq_stat);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_retry_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && $stable(cfg_max_retry) |-> stat_word[SW-1:4] <= cfg_max_retry);

  p_cause_has_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && (stat_word[1] || stat_word[2]) |-> stat_word[0]);

  p_drop_after_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_word[0] |-> !tx_valid);

endmodule

bind tx_retry_ctl tx_retry_ctl_chk #(.RW(RW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .stat_valid(stat_valid),
  .stat_word(stat_word), .irq_stat(irq_stat), .irq(irq), .irq_en(irq_en),
  .irq_clr(irq_clr), .cfg_max_retry(cfg_max_retry)
);

// File: tb/tb_tx_retry_ctl.sv
module tb_tx_retry_ctl;
  localparam int RW = 4;
  localparam int NV = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, tx_ready = 1'b1, col = 1'b0;
  logic [7:0] in_data = '0;
  logic [RW-1:0] cfg_max_retry = '0;
  logic       irq_en = 1'b0, irq_clr = 1'b0;
  logic       in_ready, tx_valid, tx_last, stat_valid, irq_stat, irq;
  logic [7:0] tx_data, stat_word;

  always #2 clk = ~clk;

  tx_retry_ctl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .col(col),
    .cfg_max_retry(cfg_max_retry), .irq_en(irq_en), .irq_clr(irq_clr),
    .stat_valid(stat_valid), .stat_word(stat_word), .irq_stat(irq_stat),
    .irq(irq)
  );

  // len, col1, col2, max_retry, backpressure, irq_en, clear_on_col, exp_status, exp_tx_bytes
  localparam int VEC [NV][9] = '{
    '{ 20, -1, -1, 3, 0, 1, 0, 8'h00,  20},
    '{100, 10, -1, 3, 0, 1, 0, 8'h10, 110},
    '{100, 30,  5, 3, 0, 0, 0, 8'h20, 135},
    '{100, 70, -1, 3, 0, 1, 1, 8'h03,  70},
    '{100, 20, 64, 3, 0, 1, 0, 8'h13,  84},
    '{100, 10, 10, 1, 0, 1, 0, 8'h15,  20},
    '{ 50, 40, -1, 0, 0, 0, 0, 8'h05,  40},
    '{ 64, 63, -1, 2, 0, 1, 0, 8'h10, 127},
    '{ 80,  0, -1, 2, 0, 1, 0, 8'h00,  80},
    '{ 30, 15, -1, 2, 1, 1, 0, 8'h10,  45},
    '{100, 64, -1, 3, 1, 1, 0, 8'h03,  64},
    '{  5,  2,  1, 2, 1, 0, 0, 8'h20,   8}
  };
  localparam string TAG [NV] = '{"R1", "R2", "R2", "R3", "R3", "R5",
                                 "R5", "R2", "R9", "R2", "R3", "R2"};

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(int v);
    int len = VEC[v][0];
    int cpos [2];
    int idx = 0, att = 0, ncol = 0, total = 0, bad = 0, dup = 0, cyc = 0;
    int lastbad = 0, colbad = 0, stall = 0;
    bit got = 1'b0;
    bit fired;
    logic [7:0] sw = '0;
    logic is_, io_;
    int seed = v * 7;
    cpos[0] = VEC[v][1];
    cpos[1] = VEC[v][2];
    @(negedge clk);
    cfg_max_retry = RW'(VEC[v][3]);
    irq_en = VEC[v][5][0];
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    while (!(got && idx >= len) && cyc < 3000) begin
      in_valid = idx < len;
      in_data  = 8'(idx + seed);
      in_last  = (idx == len - 1);
      fired    = (ncol < 2) && (cpos[ncol] >= 0) && (att == cpos[ncol]);
      col      = fired;
      tx_ready = VEC[v][4] != 0 ? cyc[0] : 1'b1;
      irq_clr  = VEC[v][6] != 0 && fired;
      #1;
      if (stat_valid) begin
        if (got) dup++;
        got = 1'b1;
        sw  = stat_word;
        is_ = irq_stat;
        io_ = irq;
      end
      if (fired) begin
        if (tx_valid) colbad++;
        ncol++;
        att = 0;
      end else if (tx_valid && tx_ready) begin
        total++;
        if (tx_data != 8'(att + seed)) bad++;
        if (tx_last != (att == len - 1)) lastbad++;
        att++;
      end
      if (ncol > 0 && !got && att < cpos[0] && in_ready && tx_valid && total > att) stall++;
      if (in_valid && in_ready) idx++;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; col = 1'b0; irq_clr = 1'b0; tx_ready = 1'b1;
    chk(cyc < 3000, TAG[v], $sformatf("vec %0d completes (R4 drain)", v), cyc, 0);
    chk(sw == 8'(VEC[v][7]), TAG[v], $sformatf("vec %0d status word (R6)", v), sw, VEC[v][7]);
    chk(total == VEC[v][8], TAG[v], $sformatf("vec %0d tx bytes (R4)", v), total, VEC[v][8]);
    chk(bad == 0 && lastbad == 0, TAG[v], $sformatf("vec %0d byte order/last (R1)", v), bad + lastbad, 0);
    chk(dup == 0, "R6", $sformatf("vec %0d single status", v), dup, 0);
    chk(colbad == 0, "R10", $sformatf("vec %0d no tx in collision cycle", v), colbad, 0);
    chk(stall == 0, "R2", $sformatf("vec %0d producer held during replay", v), stall, 0);
    chk(is_ == sw[0], "R7", $sformatf("vec %0d irq_stat", v), is_, sw[0]);
    chk(io_ == (sw[0] && VEC[v][5] != 0), "R8", $sformatf("vec %0d irq", v), io_, sw[0] && VEC[v][5] != 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!tx_valid && !stat_valid, "R1", "reset: tx_valid|stat_valid", tx_valid | stat_valid, 0);
    chk(!irq_stat && !irq, "R7", "reset: irq_stat|irq", irq_stat | irq, 0);
    chk(in_ready, "R1", "reset: in_ready", in_ready, 1);

    for (int v = 0; v < NV; v++) run_vec(v);

    run_vec(3);
    repeat (3) @(negedge clk);
    #1;
    chk(irq_stat, "R7", "flag held without clear", irq_stat, 1);
    chk(irq, "R8", "irq with enable and flag", irq, 1);
    @(negedge clk);
    irq_en = 1'b0;
    #1;
    chk(!irq, "R8", "irq masked by enable", irq, 0);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    #1;
    chk(!irq_stat, "R7", "flag cleared by write-one", irq_stat, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule